// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual word address into a physical word address. It looks the address up in a two-level page table that sits in word-addressed memory. A requester presents the virtual address, a flag telling whether it runs in system mode, and the value of the directory base register. The walker then fetches at most two table entries, one after the other, through a read port. It reports either a physical address or a page fault. A fault carries the virtual address that caused it.

The virtual address has three fields. The directory index is bits 31:22, the page index is bits 21:11 and the offset is bits 10:0. Each table entry keeps a valid flag in bit 0. A second-level entry also keeps a system-only flag in bit 1. The remaining bits of an entry hold a base word address. That base is added to the next index or to the offset. It is not concatenated with it.

Handshake rules:
- **Request input.** A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle. It stays low from the acceptance cycle until the result has been delivered. The walker registers the address, the mode flag and the directory base when it accepts them. After that the request inputs may change freely.
- **Memory read request.** While `mem_req_valid` is high, `mem_req_addr` does not change until the memory accepts it with `mem_req_ready`.
- **Memory response.** Responses arrive on `mem_rsp_valid`. The walker has no way to stall them.
- **Result.** The result is a single-cycle `done` pulse with no back-pressure. The requester must capture it in that cycle.

Top module: `xlat_walker`

## Requirements
- R1: A synchronous reset returns the walker to idle and abandons any walk in progress. During and right after reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is 0 from the cycle after acceptance until the walk has returned to idle.
- R3: If the directory base is zero, the walker reports a fault without issuing any read. `done` rises in the cycle after acceptance, with `done_fault` 1 and `fault_vaddr` equal to the accepted address.
- R4: The first read goes to the directory base plus the directory index taken from address bits 31:22. It is issued in the cycle after acceptance.
- R5: If bit 0 of the first-level entry is 0, the walk ends in a fault after exactly one read.
- R6: The second read goes to the first-level entry with only bit 0 cleared, plus the page index taken from address bits 21:11.
- R7: If bit 0 of the second-level entry is 0, the walk ends in a fault.
- R8: If bit 1 of a valid second-level entry is 1 and `req_sys` was 0 at acceptance, the walk ends in a fault. If `req_sys` was 1, the translation succeeds.
- R9: On success, `done_fault` is 0. `done_paddr` equals the second-level entry with bits 1:0 cleared, plus the offset from bits 10:0, as a 32-bit sum with carry.
- R10: `done` is high for exactly one cycle per accepted request.
- R11: Changes to `req_vaddr`, `req_sys` or `dir_base` after acceptance have no effect on the walk, its read addresses or its result.
- R12: Once `mem_req_valid` is raised, it stays high with an unchanged `mem_req_addr` until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and will take a request |
| req_vaddr | input | 32 | Virtual word address to translate |
| req_sys | input | 1 | Requester is in system mode |
| dir_base | input | 32 | Directory base register value |
| mem_req_valid | output | 1 | Table read request present |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Word address of the table read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry read back |
| done | output | 1 | One-cycle result pulse |
| done_fault | output | 1 | Result is a page fault (valid with done) |
| done_paddr | output | 32 | Physical word address (valid with done when no fault) |
| fault_vaddr | output | 32 | Virtual address of the walk (valid with done) |

## Verification
On every cycle, the checker verifies the port-level rules:
- the single-cycle `done` pulse;
- the busy state that follows an accepted request;
- the held read request under back-pressure;
- the zero-base fault that comes with no read;
- the placement of the first read;
- the idle state after reset.

Some behaviour depends on what memory returns, and only the bench scenarios can show it. This covers the second read address, the decision to fault on each level's flags and on privilege, and the added (not concatenated) physical address. The bench computes these from its own table model. It changes the request inputs in the middle of a walk and resets during a walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_WT1,
    ST_RD2,
    ST_WT2,
    ST_DONE
  } walk_st_t;
endpackage

// File: rtl/xlat_req_hold.sv
// Captures the accepted request and splits the held address into its fields.
module xlat_req_hold #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 11,
  parameter int OFF_W  = 11
) (
  input  logic                                 clk,
  input  logic                                 load,
  input  logic [ADDR_W-1:0]                    vaddr_in,
  input  logic                                 sys_in,
  input  logic [ADDR_W-1:0]                    base_in,
  output logic [ADDR_W-1:0]                    vaddr_q,
  output logic                                 sys_q,
  output logic [ADDR_W-1:0]                    base_q,
  output logic [ADDR_W-PAGE_W-OFF_W-1:0]       dir_idx,
  output logic [PAGE_W-1:0]                    page_idx,
  output logic [OFF_W-1:0]                     offset
);
  localparam int DIR_W = ADDR_W - PAGE_W - OFF_W;

  always_ff @(posedge clk) begin
    if (load) begin
      vaddr_q <= vaddr_in;
      sys_q   <= sys_in;
      base_q  <= base_in;
    end
  end

  assign dir_idx  = vaddr_q[ADDR_W-1 -: DIR_W];
  assign page_idx = vaddr_q[OFF_W +: PAGE_W];
  assign offset   = vaddr_q[OFF_W-1:0];
endmodule

// File: rtl/xlat_entry_eval.sv
// Judges one table entry: valid flag, optional privilege check, base with flag bits stripped.
module xlat_entry_eval #(
  parameter int ADDR_W     = 32,
  parameter int CLR_BITS   = 1,
  parameter bit CHECK_PRIV = 1'b0
) (
  input  logic [ADDR_W-1:0] entry,
  input  logic              sys,
  output logic              ok,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] KEEP_MASK = {{(ADDR_W-CLR_BITS){1'b1}}, {CLR_BITS{1'b0}}};

  assign ok   = entry[0] && !(CHECK_PRIV && entry[1] && !sys);
  assign base = entry & KEEP_MASK;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 11,
  parameter int OFF_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_sys,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              done_fault,
  output logic [ADDR_W-1:0] done_paddr,
  output logic [ADDR_W-1:0] fault_vaddr
);
  import xlat_pkg::*;

  localparam int DIR_W = ADDR_W - PAGE_W - OFF_W;

  walk_st_t            state;
  logic                load;
  logic [ADDR_W-1:0]   vaddr_q, base_q, pt_base_q, paddr_q;
  logic                sys_q, fault_q;
  logic [DIR_W-1:0]    dir_idx;
  logic [PAGE_W-1:0]   page_idx;
  logic [OFF_W-1:0]    offset;
  logic                l1_ok, l2_ok;
  logic [ADDR_W-1:0]   l1_base, l2_base;

  assign load = (state == ST_IDLE) && req_valid;

  xlat_req_hold #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_hold (
    .clk      (clk),
    .load     (load),
    .vaddr_in (req_vaddr),
    .sys_in   (req_sys),
    .base_in  (dir_base),
    .vaddr_q  (vaddr_q),
    .sys_q    (sys_q),
    .base_q   (base_q),
    .dir_idx  (dir_idx),
    .page_idx (page_idx),
    .offset   (offset)
  );

  xlat_entry_eval #(.ADDR_W(ADDR_W), .CLR_BITS(1), .CHECK_PRIV(1'b0)) u_lvl1 (
    .entry (mem_rsp_data),
    .sys   (sys_q),
    .ok    (l1_ok),
    .base  (l1_base)
  );

  xlat_entry_eval #(.ADDR_W(ADDR_W), .CLR_BITS(2), .CHECK_PRIV(1'b1)) u_lvl2 (
    .entry (mem_rsp_data),
    .sys   (sys_q),
    .ok    (l2_ok),
    .base  (l2_base)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      fault_q   <= 1'b0;
      paddr_q   <= '0;
      pt_base_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          fault_q <= (dir_base == '0);
          paddr_q <= '0;
          state   <= (dir_base == '0) ? ST_DONE : ST_RD1;
        end
        ST_RD1: if (mem_req_ready) state <= ST_WT1;
        ST_WT1: if (mem_rsp_valid) begin
          if (l1_ok) begin
            pt_base_q <= l1_base;
            state     <= ST_RD2;
          end else begin
            fault_q <= 1'b1;
            state   <= ST_DONE;
          end
        end
        ST_RD2: if (mem_req_ready) state <= ST_WT2;
        ST_WT2: if (mem_rsp_valid) begin
          fault_q <= !l2_ok;
          paddr_q <= l2_ok ? (l2_base + {{(ADDR_W-OFF_W){1'b0}}, offset}) : '0;
          state   <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_addr  = '0;
    if (state == ST_RD1) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = base_q + {{(ADDR_W-DIR_W){1'b0}}, dir_idx};
    end else if (state == ST_RD2) begin
      mem_req_valid = 1'b1;
      mem_req_addr  = pt_base_q + {{(ADDR_W-PAGE_W){1'b0}}, page_idx};
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign done        = (state == ST_DONE);
  assign done_fault  = fault_q;
  assign done_paddr  = paddr_q;
  assign fault_vaddr = vaddr_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 11,
  parameter int OFF_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [ADDR_W-1:0] dir_base,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done,
  input logic              done_fault,
  input logic [ADDR_W-1:0] fault_vaddr
);
  localparam int DIR_W = ADDR_W - PAGE_W - OFF_W;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !done && !mem_req_valid));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_zero_base_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && dir_base == '0) |=>
      (done && done_fault && !mem_req_valid && fault_vaddr == $past(req_vaddr)));

  assert_first_read_addr_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && dir_base != '0) |=>
      (mem_req_valid && mem_req_addr ==
        $past(dir_base) + {{(ADDR_W-DIR_W){1'b0}}, $past(req_vaddr[ADDR_W-1 -: DIR_W])}));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind xlat_walker xlat_walker_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_sys = 1'b0;
  logic [31:0] dir_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, done_fault;
  logic [31:0] done_paddr, fault_vaddr;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [4096];
  logic [31:0] rd_hist [8];
  int          rd_cnt = 0;
  bit          pend = 1'b0;
  int          lat = 0;
  logic [31:0] raddr = '0;

  xlat_walker i_xlat_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_sys(req_sys), .dir_base(dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_paddr(done_paddr), .fault_vaddr(fault_vaddr)
  );

  always #(CLK_P/2) clk = ~clk;

  // Memory model: random acceptance, 1 to 3 cycles of response latency.
  always @(posedge clk) begin
    mem_req_ready <= ($urandom % 3) != 0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready && !pend) begin
      pend  <= 1'b1;
      lat   <= $urandom % 3;
      raddr <= mem_req_addr;
      rd_hist[rd_cnt % 8] <= mem_req_addr;
      rd_cnt <= rd_cnt + 1;
    end else if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[raddr[11:0]];
        pend <= 1'b0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic walk(input string tg, input logic [31:0] va, input bit sy,
                      input logic [31:0] bs, input bit perturb);
    logic        e_fault;
    logic [31:0] e_pa, a0, a1, l1, l2;
    int          e_n, start, cyc;
    e_fault = 1'b0; e_pa = '0; a0 = '0; a1 = '0; e_n = 0;
    if (bs == 0) begin
      e_fault = 1'b1;
    end else begin
      a0 = bs + {22'd0, va[31:22]};
      l1 = mem[a0[11:0]];
      e_n = 1;
      if (!l1[0]) e_fault = 1'b1;
      else begin
        a1 = (l1 & ~32'd1) + {21'd0, va[21:11]};
        l2 = mem[a1[11:0]];
        e_n = 2;
        if (!l2[0] || (l2[1] && !sy)) e_fault = 1'b1;
        else e_pa = (l2 & ~32'd3) + {21'd0, va[10:0]};
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_sys = sy; dir_base = bs;
    start = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    if (perturb) begin
      req_vaddr = $urandom; dir_base = $urandom | 32'd1; req_sys = ~sy;
    end
    chk("R2", "req_ready while busy", {31'd0, req_ready}, 32'd0);
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 200) begin
      chk("R10", "done never arrived", 32'd0, 32'd1);
    end else begin
      if (bs == 0) chk("R3", "done latency", cyc, 0);
      chk(tg, "done_fault", {31'd0, done_fault}, {31'd0, e_fault});
      if (e_fault) chk(perturb ? "R11" : tg, "fault_vaddr", fault_vaddr, va);
      else chk(perturb ? "R11" : "R9", "done_paddr", done_paddr, e_pa);
      @(negedge clk);
      chk("R10", "done after one cycle", {31'd0, done}, 32'd0);
    end
    chk(bs == 0 ? "R3" : (e_n == 1 ? "R5" : "R6"), "read count", rd_cnt - start, e_n);
    if (e_n >= 1) chk("R4", "first read addr", rd_hist[start % 8], a0);
    if (e_n == 2) chk("R6", "second read addr", rd_hist[(start + 1) % 8], a1);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "done in reset", {31'd0, done}, 32'd0);
    chk("R1", "mem_req_valid in reset", {31'd0, mem_req_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Directed: zero base.
    walk("R3", 32'hDEAD_BEEF, 1'b1, 32'd0, 1'b0);
    // Directed: first-level invalid.
    mem[16 + 5] = 32'h0000_0A00;
    walk("R5", {10'd5, 11'd3, 11'd7}, 1'b1, 32'd16, 1'b0);
    // Directed: first-level bit1 kept in table base (only bit 0 cleared).
    mem[16 + 6] = 32'h0000_0803;
    mem[12'h802 + 4] = 32'h0000_0FFD;
    walk("R6", {10'd6, 11'd4, 11'h7FF}, 1'b1, 32'd16, 1'b0);
    // Directed: add carry, base 0xFFC + offset 0x7FF.
    mem[12'h802 + 9] = 32'h0000_0FFD;
    walk("R9", {10'd6, 11'd9, 11'h7FF}, 1'b0, 32'd16, 1'b0);
    // Directed: second-level invalid.
    mem[12'h802 + 10] = 32'h0001_2340;
    walk("R7", {10'd6, 11'd10, 11'd1}, 1'b1, 32'd16, 1'b0);
    // Directed: system-only page, user then system.
    mem[12'h802 + 11] = 32'h0004_5003;
    walk("R8", {10'd6, 11'd11, 11'd2}, 1'b0, 32'd16, 1'b0);
    walk("R8", {10'd6, 11'd11, 11'd2}, 1'b1, 32'd16, 1'b0);
    // Directed: inputs change mid-walk.
    walk("R11", {10'd6, 11'd11, 11'd3}, 1'b1, 32'd16, 1'b1);
    walk("R11", {10'd6, 11'd10, 11'd3}, 1'b0, 32'd16, 1'b1);

    // Reset in the middle of a walk.
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {10'd6, 11'd11, 11'd3}; req_sys = 1'b1; dir_base = 32'd16;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after mid-walk reset", {31'd0, req_ready}, 32'd1);
    chk("R1", "mem_req_valid after mid-walk reset", {31'd0, mem_req_valid}, 32'd0);
    chk("R1", "done after mid-walk reset", {31'd0, done}, 32'd0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1", "no spurious done", {31'd0, done}, 32'd0);

    // Random walks.
    for (int n = 0; n < 300; n++) begin
      logic [31:0] bs, va, pt, e1, e2;
      logic [9:0]  di;
      logic [10:0] pi, of;
      int          kind;
      bs   = ($urandom % 1024) + 1;
      di   = 10'($urandom);
      pi   = 11'($urandom % 1024);
      of   = 11'($urandom);
      va   = {di, pi, of};
      pt   = 32'd2048 + (($urandom % 512) * 2);
      kind = $urandom % 8;
      e1   = (kind == 0) ? (pt & ~32'd1) : (pt | 32'd1);
      e2   = $urandom;
      if (kind == 1) e2[0] = 1'b0;
      else e2[0] = 1'b1;
      mem[12'(bs + {22'd0, di})] = e1;
      mem[12'(pt + {21'd0, pi})] = e2;
      if (kind == 7) bs = 32'd0;
      walk(kind == 0 ? "R5" : (kind == 1 ? "R7" : (kind == 7 ? "R3" : "R8")),
           va, 1'($urandom), bs, (kind == 6));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule